// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Flags

This block is the receive-side character queue of one serial channel. The receive shift logic hands it each finished character along with three error flags: a parity mismatch, a missing stop bit and a line break. The queue holds up to sixteen such characters in arrival order. A CPU-side read port removes the oldest one. The error flags of the oldest stored character are always on view. A sticky summary flag tells software that an errored character sits somewhere in the queue.

The block produces four kinds of indication. Data-ready shows that the queue is not empty. Overrun shows that a character arrived while the queue was full. The trigger indication fires when occupancy reaches a programmable threshold. The idle indication fires when characters have sat unread for four character times with no new arrival. The baud logic supplies a one-cycle strobe once per character time. A mode input selects between buffered operation and a single holding register, which keeps only the newest character.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty, and `data_ready`, `overrun`, `trig_irq`, `timeout_irq` and `err_summary` are all low.
- R2: In buffered mode up to 16 characters are stored in arrival order. A `pop` on a non-empty queue places the oldest character on `rd_data` in the next cycle, and `data_ready` is high exactly while the queue holds a character.
- R3: In buffered mode, a push while the queue holds 16 characters and no pop is present sets `overrun` in the next cycle. That character is discarded. `overrun` stays set until a `status_rd` pulse.
- R4: `trig_sel` values 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 characters. In buffered mode, `trig_irq` is high exactly while occupancy is at or above the selected threshold.
- R5: `timeout_irq` rises once four `char_tick` strobes have been seen since the last push or pop, provided the queue is non-empty in buffered mode. Any push or pop restarts the count, and a pop clears a pending indication.
- R6: `head_perr`, `head_ferr` and `head_brk` show the flags stored with the oldest character, and read low when the queue is empty.
- R7: In buffered mode, `err_summary` is set when an errored character is stored. A `status_rd` clears it only if no errored character remains stored.
- R8: A `flush` pulse, or any change of `fifo_en`, empties the queue in the next cycle.
- R9: With `fifo_en` low the queue holds one character. A push onto a held character replaces it and sets `overrun`. The threshold is one character, `timeout_irq` stays low and `err_summary` reads low.
- R10: A `pop` on an empty queue leaves `rd_data` and the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = buffered mode, 0 = single holding register |
| trig_sel | input | 2 | Threshold select (1/4/8/14) |
| flush | input | 1 | Empty the queue |
| push_valid | input | 1 | A received character is presented |
| push_data | input | 8 | Received character |
| push_perr | input | 1 | Parity error for the presented character |
| push_ferr | input | 1 | Stop-bit error for the presented character |
| push_brk | input | 1 | Break seen for the presented character |
| pop | input | 1 | CPU read of the data register |
| status_rd | input | 1 | CPU read of the line status |
| char_tick | input | 1 | One-cycle strobe per character time |
| rd_data | output | 8 | Last character removed by a pop |
| head_perr | output | 1 | Parity flag of the oldest character |
| head_ferr | output | 1 | Stop-bit flag of the oldest character |
| head_brk | output | 1 | Break flag of the oldest character |
| data_ready | output | 1 | Queue not empty |
| err_summary | output | 1 | Sticky: errored character stored |
| overrun | output | 1 | Sticky: character lost |
| trig_irq | output | 1 | Occupancy at or above threshold |
| timeout_irq | output | 1 | Idle time-out pending |

## Verification
The hardest situation to reach is the full-queue push, and it has to be reached under every threshold setting. The stimulus gets there by filling the queue one character at a time for each `trig_sel` value, checking the trigger output after every push, then pushing a seventeenth character and draining the whole queue. The drain compares each character and its flags with values the bench computes from the position in the sequence. The idle time-out is a second hard case: a push inserted after three strobes must restart the count before four more strobes raise the indication.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;

  // threshold in characters for the two-bit select
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic entry_err(input rxq_entry_t e);
    return e.perr | e.ferr | e.brk;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rxq_entry_t    wdata,
  input  logic [AW-1:0] raddr,
  output rxq_entry_t    rdata
);
  rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic idle_empty,
  input  logic tick,
  output logic expired
);
  logic [CW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (!rst_n)                          ticks <= '0;
    else if (restart || idle_empty)      ticks <= '0;
    else if (tick && ticks != CW'(LIMIT)) ticks <= ticks + CW'(1);
  end

  assign expired = (ticks == CW'(LIMIT));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [RXQ_DW-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop,
  input  logic              status_rd,
  input  logic              char_tick,
  output logic [RXQ_DW-1:0] rd_data,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              head_brk,
  output logic              data_ready,
  output logic              err_summary,
  output logic              overrun,
  output logic              trig_irq,
  output logic              timeout_irq
);
  logic [CW-1:0] cnt, err_cnt, cap, level;
  logic [AW-1:0] wp, rp, waddr;
  logic          mode_q, err_sum_q, ovr_q;
  logic          flush_evt, nonempty, full, accept, take, drop, overwrite, we;
  logic          expired;
  rxq_entry_t    new_e, head_e;

  // named internal events
  assign flush_evt = flush | (fifo_en != mode_q);
  assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  assign level     = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
  assign nonempty  = (cnt != '0);
  assign full      = (cnt == cap);
  assign take      = pop & nonempty & ~flush_evt;
  assign accept    = push_valid & ~flush_evt & (~full | take);
  assign drop      = push_valid & ~flush_evt & full & ~take & fifo_en;
  assign overwrite = push_valid & ~flush_evt & full & ~take & ~fifo_en;
  assign we        = accept | overwrite;
  assign waddr     = overwrite ? rp : wp;

  assign new_e = '{brk: push_brk, ferr: push_ferr, perr: push_perr, data: push_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(new_e),
    .raddr(rp), .rdata(head_e)
  );

  rxq_idle_timer #(.LIMIT(TO_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(push_valid | pop | flush_evt),
    .idle_empty(~nonempty), .tick(char_tick), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= fifo_en;
      cnt       <= '0;
      err_cnt   <= '0;
      wp        <= '0;
      rp        <= '0;
      rd_data   <= '0;
      err_sum_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (take) rd_data <= head_e.data;
      if (drop || overwrite)  ovr_q <= 1'b1;
      else if (status_rd)     ovr_q <= 1'b0;
      if (flush_evt) begin
        cnt       <= '0;
        err_cnt   <= '0;
        wp        <= '0;
        rp        <= '0;
        err_sum_q <= 1'b0;
      end else begin
        cnt     <= cnt + CW'(accept) - CW'(take);
        wp      <= wp + AW'(accept);
        rp      <= rp + AW'(take);
        err_cnt <= err_cnt + CW'(we & entry_err(new_e))
                           - CW'((take | overwrite) & entry_err(head_e));
        if (we && entry_err(new_e))       err_sum_q <= 1'b1;
        else if (status_rd && err_cnt == '0) err_sum_q <= 1'b0;
      end
    end
  end

  assign data_ready  = nonempty;
  assign head_perr   = nonempty & head_e.perr;
  assign head_ferr   = nonempty & head_e.ferr;
  assign head_brk    = nonempty & head_e.brk;
  assign err_summary = err_sum_q & fifo_en;
  assign overrun     = ovr_q;
  assign trig_irq    = (cnt >= level);
  assign timeout_irq = fifo_en & nonempty & expired;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          push_valid,
  input logic          pop,
  input logic          data_ready,
  input logic          overrun,
  input logic          trig_irq,
  input logic          timeout_irq,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] cnt,
  input logic          full,
  input logic          flush_evt
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && fifo_en && !pop && !flush_evt) |=> overrun);

  assert_trig_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> data_ready);

  assert_timeout_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> data_ready);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> !data_ready);

  assert_single_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flush_evt) |-> (cnt <= CW'(1)));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !data_ready && !push_valid && !flush_evt) |=> $stable(rd_data));
endmodule

bind rx_err_fifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
  .pop(pop), .data_ready(data_ready), .overrun(overrun), .trig_irq(trig_irq),
  .timeout_irq(timeout_irq), .rd_data(rd_data), .cnt(cnt), .full(full),
  .flush_evt(flush_evt)
);

// File: tb/sim_rx_err_fifo.sv
module sim_rx_err_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       flush = 1'b0, push_valid = 1'b0, pop = 1'b0, status_rd = 1'b0, char_tick = 1'b0;
  logic [7:0] push_data = 8'd0;
  logic       push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
  logic [7:0] rd_data;
  logic       head_perr, head_ferr, head_brk, data_ready, err_summary, overrun, trig_irq, timeout_irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rx_err_fifo u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_push(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; push_perr = p; push_ferr = f; push_brk = b;
    @(negedge clk);
    push_valid = 1'b0; push_perr = 1'b0; push_ferr = 1'b0; push_brk = 1'b0;
  endtask

  task automatic pulse(input int which);  // 0 pop, 1 status_rd, 2 flush, 3 char_tick
    @(negedge clk);
    case (which)
      0: pop = 1'b1;
      1: status_rd = 1'b1;
      2: flush = 1'b1;
      default: char_tick = 1'b1;
    endcase
    @(negedge clk);
    pop = 1'b0; status_rd = 1'b0; flush = 1'b0; char_tick = 1'b0;
  endtask

  function automatic int thresh(input int s);
    int t;
    t = 1 << (s + s);  // 1, 4, 16 ...
    if (s == 2) t = 8;
    if (s == 3) t = 14;
    return t;
  endfunction

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s * 11 + 5) % 256);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "data_ready", data_ready, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "trig_irq", trig_irq, 0);
    chk("R1", "timeout_irq", timeout_irq, 0);
    chk("R1", "err_summary", err_summary, 0);

    // threshold sweep with fill, overrun and ordered drain
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      pulse(2);
      pulse(1);
      for (int i = 0; i < 16; i++) begin
        do_push(pat(i, s), (i % 3) == 1, (i % 5) == 2, i == 7);
        chk("R4", "trig_irq fill", trig_irq, int'((i + 1) >= thresh(s)));
        chk("R2", "data_ready fill", data_ready, 1);
      end
      chk("R3", "overrun before full push", overrun, 0);
      do_push(8'hEE, 1'b0, 1'b0, 1'b0);
      chk("R3", "overrun on full push", overrun, 1);
      chk("R7", "err_summary after errored stores", err_summary, 1);
      for (int i = 0; i < 16; i++) begin
        chk("R6", "head_perr", head_perr, int'((i % 3) == 1));
        chk("R6", "head_ferr", head_ferr, int'((i % 5) == 2));
        chk("R6", "head_brk", head_brk, int'(i == 7));
        pulse(0);
        chk("R2", "rd_data order", rd_data, pat(i, s));
        chk("R4", "trig_irq drain", trig_irq, int'((15 - i) >= thresh(s)));
      end
      chk("R2", "data_ready drained", data_ready, 0);
      chk("R6", "head flags empty", {head_perr, head_ferr, head_brk}, 0);
      chk("R3", "overrun sticky", overrun, 1);
      pulse(1);
      chk("R3", "overrun cleared by status read", overrun, 0);
      chk("R7", "err_summary cleared when none stored", err_summary, 0);
    end

    // idle time-out
    trig_sel = 2'd3;
    do_push(8'h11, 0, 0, 0);
    do_push(8'h22, 0, 0, 0);
    repeat (3) pulse(3);
    chk("R5", "no timeout after 3 ticks", timeout_irq, 0);
    do_push(8'h33, 0, 0, 0);
    repeat (3) pulse(3);
    chk("R5", "push restarted timer", timeout_irq, 0);
    pulse(3);
    chk("R5", "timeout after 4 ticks", timeout_irq, 1);
    pulse(0);
    chk("R5", "pop clears timeout", timeout_irq, 0);
    chk("R2", "rd_data first", rd_data, 8'h11);
    repeat (3) pulse(3);
    chk("R5", "no timeout 3 ticks after pop", timeout_irq, 0);
    pulse(3);
    chk("R5", "timeout again", timeout_irq, 1);

    // error summary only clears when no errored entry remains
    pulse(2);
    chk("R8", "flush empties", data_ready, 0);
    do_push(8'h44, 1, 0, 0);
    do_push(8'h55, 0, 0, 0);
    pulse(1);
    chk("R7", "err_summary held while errored stored", err_summary, 1);
    pulse(0);
    chk("R7", "err_summary held until status read", err_summary, 1);
    pulse(1);
    chk("R7", "err_summary cleared", err_summary, 0);
    chk("R2", "one left", data_ready, 1);

    // mode toggle empties, then single-register mode
    do_push(8'h66, 0, 0, 0);
    @(negedge clk);
    fifo_en = 1'b0;
    @(negedge clk);
    chk("R8", "mode toggle empties", data_ready, 0);
    do_push(8'hA1, 0, 1, 0);
    chk("R9", "holding data_ready", data_ready, 1);
    chk("R9", "holding trig at one", trig_irq, 1);
    chk("R9", "err_summary low in holding mode", err_summary, 0);
    chk("R6", "head_ferr holding", head_ferr, 1);
    do_push(8'hB2, 0, 0, 0);
    chk("R9", "overwrite sets overrun", overrun, 1);
    chk("R6", "head_ferr replaced", head_ferr, 0);
    repeat (4) pulse(3);
    chk("R9", "no timeout in holding mode", timeout_irq, 0);
    pulse(0);
    chk("R9", "newest kept", rd_data, 8'hB2);
    chk("R9", "emptied", data_ready, 0);
    pulse(0);
    chk("R10", "empty pop keeps rd_data", rd_data, 8'hB2);
    chk("R10", "empty pop keeps empty", data_ready, 0);
    do_push(8'hC3, 0, 0, 0);
    pulse(0);
    chk("R10", "count intact after empty pop", rd_data, 8'hC3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule